// File: doc/BRIEF.md
# Packed double-to-single float converter

This block narrows packed IEEE-754 binary64 lanes taken from a 256-bit source vector into binary32 results. The results are packed at the bottom of a 256-bit destination. The bits above them are then zeroed or kept from the previous destination value, depending on which of three operand variants is selected. Every lane applies the requested rounding direction on its own. The lanes also handle gradual underflow, overflow saturation and NaN quieting. Five exception flags come out, each ORed across the lanes that take part in the operation.

Operations enter through a valid/ready handshake and go through one register stage. The caller supplies three things with each operation: the source vector, the current destination contents and a 4-bit reserved field. In the two zeroing variants that field must be all ones. Any other value there makes the block report an undefined-operation fault. On a fault it returns the old destination unchanged and clears the flags.

Top module: `fpn_narrow`

## Requirements
- R1: Result lane i (destination bits [32i+31:32i]) is the binary32 conversion of source bits [64i+63:64i].
- R2: Variant select 2'b00 (keep-upper, 2 lanes) and 2'b01 (zero-upper, 2 lanes) convert lanes 0 and 1 only. Variant 2'b10 (zero-upper, 4 lanes) converts lanes 0 to 3. Lanes that take no part have no effect on the result or on the flags.
- R3: In variant 2'b00, destination bits [127:64] are zero and bits [255:128] equal the old destination input.
- R4: In variant 2'b01, destination bits [255:64] are zero.
- R5: In variant 2'b10, destination bits [255:128] are zero.
- R6: Rounding mode 2'b00 rounds to nearest with ties to even. 2'b01 rounds toward negative infinity, 2'b10 toward positive infinity and 2'b11 toward zero. Any inexact result sets the precision flag.
- R7: When the rounded magnitude exceeds the largest finite binary32 value, overflow and precision are set. The result is infinity under nearest rounding and under rounding toward the operand's own infinity; otherwise it is the largest finite value (7F7FFFFF magnitude), keeping the sign.
- R8: Results below the normal range are denormalized and rounded correctly. Underflow is set when the exact value lies below 2^-126 before rounding and the result is inexact. A nonzero subnormal binary64 input sets the denormal flag.
- R9: Zeros and infinities pass through with their sign and raise no flags. A NaN gives a NaN with the same sign, exponent all ones, quiet bit (bit 22) set and bits [21:0] taken from source fraction bits [50:29]. A NaN whose source fraction bit 51 is clear also sets invalid.
- R10: Flags are packed as bit 0 invalid, bit 1 denormal, bit 2 overflow, bit 3 underflow, bit 4 precision, each ORed over the active lanes.
- R11: The fault is raised, with the destination equal to the old destination and flags zero, when variant 2'b11 is selected or when a zeroing variant (2'b01, 2'b10) has a reserved field other than 4'b1111. Variant 2'b00 ignores the reserved field.
- R12: An operation is accepted when in_valid and in_ready are both high, with in_ready = !out_valid || out_ready. Its result is on the outputs with out_valid high after the next clock edge, and it stays stable while out_valid is high and out_ready is low.
- R13: Synchronous active-high reset clears out_valid, dst, flags and ud_fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| src | input | 256 | Packed binary64 source lanes |
| old_dst | input | 256 | Current destination contents |
| vsel | input | 2 | Operand variant select |
| rmode | input | 2 | Rounding direction |
| rsvd | input | 4 | Reserved field, must be 4'b1111 in zeroing variants |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed |
| dst | output | 256 | New destination value |
| flags | output | 5 | Exception flags of the operation |
| ud_fault | output | 1 | Undefined-operation fault |

## Verification
The bench goes after exact ties at the rounding point. A converter that always rounded half up, or that ignored the direction, would give odd mantissas or leave the last bit unchanged where the table expects otherwise. It also probes values that round across the largest finite value and up from the subnormal range. A design that checked overflow before rounding, or did not let the carry reach the exponent, would return a finite or subnormal value where infinity or 2^-126 is due. The bench also checks signaling NaNs, inputs that are subnormal in binary64 under each direction, flag ORing across lanes, the three upper-bit rules and the reserved-field fault, so that a swapped lane, a leaked inactive-lane flag or a wrongly kept upper half shows up at the ports.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  localparam int DBL_W  = 64;
  localparam int SGL_W  = 32;
  localparam int FLAG_W = 5;
  localparam logic [3:0] RSVD_OK = 4'hF;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    VR_KEEP2 = 2'b00,
    VR_ZERO2 = 2'b01,
    VR_ZERO4 = 2'b10,
    VR_BAD   = 2'b11
  } vsel_e;

  // packed MSB first: bit 4 precision ... bit 0 invalid
  typedef struct packed {
    logic inexact;
    logic underflow;
    logic overflow;
    logic denorm;
    logic invalid;
  } flags_t;

endpackage

// File: rtl/fpn_lane.sv
module fpn_lane
  import fpn_pkg::*;
(
  input  logic [DBL_W-1:0] din,
  input  rmode_e           rm,
  output logic [SGL_W-1:0] dout,
  output flags_t           fl
);

  logic               s;
  logic [10:0]        e;
  logic [51:0]        f;
  logic [52:0]        m;
  logic signed [12:0] eb;
  logic signed [13:0] need;
  logic [5:0]         d;
  logic [86:0]        ext;
  logic [22:0]        frac;
  logic               rb, st, inexact, inc;
  logic [7:0]         expf;
  logic [30:0]        sum;
  logic               big, ovf_inf;

  assign s = din[63];
  assign e = din[62:52];
  assign f = din[51:0];

  // datapath: align mantissa to the binary32 grid, then round
  always_comb begin
    m    = {e != 11'd0, f};
    eb   = $signed({2'b00, (e == 11'd0) ? 11'd1 : e}) - 13'sd896;
    need = 14'sd1 - {eb[12], eb};
    if (eb > 13'sd0)        d = 6'd0;
    else if (need > 14'sd34) d = 6'd34;
    else                     d = need[5:0];
    ext     = {m, 34'b0} >> d;
    frac    = ext[85:63];
    rb      = ext[62];
    st      = |ext[61:0];
    inexact = rb | st;
    expf    = (eb > 13'sd0) ? eb[7:0] : 8'd0;
    case (rm)
      RM_NEAR: inc = rb & (st | frac[0]);
      RM_UP:   inc = ~s & inexact;
      RM_DOWN: inc = s & inexact;
      default: inc = 1'b0;
    endcase
    sum     = {expf, frac} + 31'(inc);
    big     = (eb > 13'sd254) || (sum[30:23] == 8'hFF);
    ovf_inf = (rm == RM_NEAR) || (rm == RM_UP && !s) || (rm == RM_DOWN && s);
  end

  // special-value selection and flags
  always_comb begin
    fl   = '0;
    dout = {s, sum};
    if (e == 11'h7FF) begin
      if (f == 52'd0) begin
        dout = {s, 8'hFF, 23'd0};
      end else begin
        dout       = {s, 8'hFF, 1'b1, f[50:29]};
        fl.invalid = ~f[51];
      end
    end else if (e == 11'd0 && f == 52'd0) begin
      dout = {s, 31'd0};
    end else begin
      fl.denorm = (e == 11'd0);
      if (big) begin
        fl.overflow = 1'b1;
        fl.inexact  = 1'b1;
        dout = ovf_inf ? {s, 8'hFF, 23'd0} : {s, 8'hFE, 23'h7FFFFF};
      end else begin
        fl.inexact   = inexact;
        fl.underflow = inexact && (eb < 13'sd1);
      end
    end
  end

  always_comb begin
    // hidden bit survives alignment only for normal-range results
    assert_hidden_R8: assert (ext[86] == (eb >= 13'sd1))
      else $error("hidden bit misaligned");
    if (e == 11'h7FF && f != 52'd0) begin
      assert_nan_quiet_R9: assert (dout[30:22] == 9'h1FF && dout[31] == s)
        else $error("NaN not quieted");
    end
    if (fl.overflow) begin
      assert_ovf_mag_R7: assert (dout[30:0] == 31'h7F800000 || dout[30:0] == 31'h7F7FFFFF)
        else $error("overflow magnitude wrong");
    end
  end

endmodule

// File: rtl/fpn_merge.sv
module fpn_merge
  import fpn_pkg::*;
#(
  parameter  int NLANES = 4,
  localparam int VW     = NLANES * DBL_W,
  localparam int CW     = NLANES * SGL_W,
  localparam int NSLOT  = VW / SGL_W
) (
  input  logic [CW-1:0] conv,
  input  logic [VW-1:0] old_dst,
  input  vsel_e         vsel,
  input  logic          fault,
  output logic [VW-1:0] dst
);

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    if (k < NLANES / 2) begin : g_narrow
      assign dst[k*SGL_W +: SGL_W] = fault ? old_dst[k*SGL_W +: SGL_W]
                                           : conv[k*SGL_W +: SGL_W];
    end else if (k < NLANES) begin : g_wide
      assign dst[k*SGL_W +: SGL_W] = fault ? old_dst[k*SGL_W +: SGL_W]
                                   : (vsel == VR_ZERO4) ? conv[k*SGL_W +: SGL_W]
                                   : '0;
    end else begin : g_upper
      assign dst[k*SGL_W +: SGL_W] = (fault || vsel == VR_KEEP2)
                                   ? old_dst[k*SGL_W +: SGL_W] : '0;
    end
  end

endmodule

// File: rtl/fpn_narrow.sv
module fpn_narrow
  import fpn_pkg::*;
#(
  parameter  int NLANES = 4,
  localparam int VW     = NLANES * DBL_W,
  localparam int CW     = NLANES * SGL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VW-1:0]     src,
  input  logic [VW-1:0]     old_dst,
  input  logic [1:0]        vsel,
  input  logic [1:0]        rmode,
  input  logic [3:0]        rsvd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VW-1:0]     dst,
  output logic [FLAG_W-1:0] flags,
  output logic              ud_fault
);

  vsel_e              vs;
  rmode_e             rm;
  logic               fire, fault;
  logic [CW-1:0]      conv;
  logic [FLAG_W-1:0]  lfl [NLANES];
  logic [FLAG_W-1:0]  fl_or;
  logic [VW-1:0]      dst_d;
  int                 act;

  assign vs       = vsel_e'(vsel);
  assign rm       = rmode_e'(rmode);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign fault    = (vs == VR_BAD) || (vs != VR_KEEP2 && rsvd != RSVD_OK);

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    flags_t lf;
    fpn_lane u_lane (
      .din  (src[i*DBL_W +: DBL_W]),
      .rm   (rm),
      .dout (conv[i*SGL_W +: SGL_W]),
      .fl   (lf)
    );
    assign lfl[i] = lf;
  end

  always_comb begin
    act   = (vs == VR_ZERO4) ? NLANES : NLANES / 2;
    fl_or = '0;
    for (int i = 0; i < NLANES; i++) begin
      if (i < act) fl_or = fl_or | lfl[i];
    end
  end

  fpn_merge #(.NLANES(NLANES)) u_merge (
    .conv    (conv),
    .old_dst (old_dst),
    .vsel    (vs),
    .fault   (fault),
    .dst     (dst_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst       <= '0;
      flags     <= '0;
      ud_fault  <= 1'b0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        dst       <= dst_d;
        flags     <= fault ? '0 : fl_or;
        ud_fault  <= fault;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_take_R12: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);

  assert_stall_R12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(dst) && $stable(flags)));

  assert_fault_keep_R11: assert property (@(posedge clk) disable iff (rst)
    (fire && fault) |=> (ud_fault && dst == $past(old_dst) && flags == '0));

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (fire && !fault && vs != VR_KEEP2) |=> (dst[VW-1:VW/2] == '0));

endmodule

// File: tb/fpn_narrow_tb.sv
`timescale 1ns/1ps
module fpn_narrow_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] src = '0;
  logic [255:0] old_dst = '0;
  logic [1:0]   vsel = 2'b00;
  logic [1:0]   rmode = 2'b00;
  logic [3:0]   rsvd = 4'hF;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] dst;
  logic [4:0]   flags;
  logic         ud_fault;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fpn_narrow dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src(src), .old_dst(old_dst), .vsel(vsel), .rmode(rmode), .rsvd(rsvd),
    .out_valid(out_valid), .out_ready(out_ready), .dst(dst),
    .flags(flags), .ud_fault(ud_fault)
  );

  // {rmode, binary64 input, expected binary32, expected flags}
  localparam int NV = 29;
  localparam logic [102:0] VEC [NV] = '{
    {2'd0, 64'h3FF0000000000000, 32'h3F800000, 5'h00},  // R9 group
    {2'd3, 64'hC004000000000000, 32'hC0200000, 5'h00},
    {2'd0, 64'h8000000000000000, 32'h80000000, 5'h00},
    {2'd1, 64'h7FF0000000000000, 32'h7F800000, 5'h00},
    {2'd0, 64'h7FF4000000000000, 32'h7FE00000, 5'h01},
    {2'd2, 64'hFFF8000000000000, 32'hFFC00000, 5'h00},
    {2'd0, 64'h3FF0000010000000, 32'h3F800000, 5'h10},  // R6 group
    {2'd2, 64'h3FF0000010000000, 32'h3F800001, 5'h10},
    {2'd0, 64'h3FF0000030000000, 32'h3F800002, 5'h10},
    {2'd3, 64'h3FF0000030000000, 32'h3F800001, 5'h10},
    {2'd1, 64'hBFF0000010000000, 32'hBF800001, 5'h10},
    {2'd2, 64'hBFF0000010000000, 32'hBF800000, 5'h10},
    {2'd0, 64'h7FE0000000000000, 32'h7F800000, 5'h14},  // R7 group
    {2'd3, 64'h7FE0000000000000, 32'h7F7FFFFF, 5'h14},
    {2'd1, 64'hFFE0000000000000, 32'hFF800000, 5'h14},
    {2'd2, 64'hFFE0000000000000, 32'hFF7FFFFF, 5'h14},
    {2'd0, 64'h47EFFFFFE0000000, 32'h7F7FFFFF, 5'h00},
    {2'd0, 64'h47EFFFFFF0000000, 32'h7F800000, 5'h14},
    {2'd3, 64'h47EFFFFFF0000000, 32'h7F7FFFFF, 5'h10},
    {2'd0, 64'h3810000000000000, 32'h00800000, 5'h00},  // R8 group
    {2'd0, 64'h36A0000000000000, 32'h00000001, 5'h00},
    {2'd0, 64'h3690000000000000, 32'h00000000, 5'h18},
    {2'd2, 64'h3690000000000000, 32'h00000001, 5'h18},
    {2'd0, 64'h0000000000000001, 32'h00000000, 5'h1A},
    {2'd1, 64'h8000000000000001, 32'h80000001, 5'h1A},
    {2'd0, 64'h380FFFFFE0000000, 32'h00800000, 5'h18},
    {2'd3, 64'h380FFFFFE0000000, 32'h007FFFFF, 5'h18},
    {2'd0, 64'hFFF0000000000001, 32'hFFC00000, 5'h01},  // R9 group
    {2'd3, 64'hFFF0000000000000, 32'hFF800000, 5'h00}
  };

  localparam logic [63:0] ONE = 64'h3FF0000000000000;
  localparam logic [63:0] M25 = 64'hC004000000000000;
  localparam logic [63:0] BIG = 64'h7FE0000000000000;
  localparam logic [63:0] SNN = 64'h7FF4000000000000;
  localparam logic [63:0] TIE = 64'h3FF0000010000000;
  localparam logic [255:0] OLD = {8{32'hDEADBEEF}};

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [255:0] s, input logic [255:0] o,
                        input logic [1:0] v, input logic [1:0] r, input logic [3:0] rs);
    @(negedge clk);
    src = s; old_dst = o; vsel = v; rmode = r; rsvd = rs; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic string grp(input int k);
    if (k < 6)  return "R9 special";
    if (k < 12) return "R6 rounding";
    if (k < 19) return "R7 overflow";
    if (k < 27) return "R8 underflow";
    return "R9 special";
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog expired: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13 reset state
    check("R13 out_valid", 256'(out_valid), 256'(0));
    check("R13 dst", dst, '0);
    check("R13 flags+fault", 256'({flags, ud_fault}), 256'(0));
    rst = 1'b0;

    // table walk: each vector in lane k%4 of a 4-lane op (R1, R5, R10)
    for (int k = 0; k < NV; k++) begin
      logic [1:0]  r;
      logic [63:0] din;
      logic [31:0] ex;
      logic [4:0]  ef;
      int          ln;
      {r, din, ex, ef} = VEC[k];
      ln = k % 4;
      run_op(256'(din) << (ln * 64), OLD, 2'b10, r, 4'hF);
      check($sformatf("R1 %s vec %0d dst", grp(k), k), dst, 256'(ex) << (ln * 32));
      check($sformatf("R10 %s vec %0d flags", grp(k), k), 256'(flags), 256'(ef));
    end

    // R3 keep-upper variant; reserved field ignored (R11), inactive lanes ignored (R2)
    run_op({BIG, BIG, M25, ONE}, OLD, 2'b00, 2'b00, 4'h0);
    check("R3 keep-upper dst", dst, {OLD[255:128], 64'd0, 32'hC0200000, 32'h3F800000});
    check("R2 keep-upper flags", 256'(flags), 256'(0));
    check("R11 rsvd ignored fault", 256'(ud_fault), 256'(0));

    // R4 zero-upper 2-lane
    run_op({BIG, BIG, M25, ONE}, OLD, 2'b01, 2'b00, 4'hF);
    check("R4 zero2 dst", dst, {192'd0, 32'hC0200000, 32'h3F800000});

    // R5/R10 four lanes, flags ORed
    run_op({SNN, BIG, TIE, ONE}, OLD, 2'b10, 2'b00, 4'hF);
    check("R5 zero4 dst", dst, {128'd0, 32'h7FE00000, 32'h7F800000, 32'h3F800000, 32'h3F800000});
    check("R10 ored flags", 256'(flags), 256'(5'h15));

    // R2 same source, two lanes: lanes 2,3 contribute nothing
    run_op({SNN, BIG, TIE, ONE}, OLD, 2'b01, 2'b00, 4'hF);
    check("R2 two-lane flags", 256'(flags), 256'(5'h10));
    check("R2 two-lane dst", dst, {192'd0, 32'h3F800000, 32'h3F800000});

    // R11 faults
    run_op({SNN, BIG, TIE, ONE}, OLD, 2'b10, 2'b00, 4'h7);
    check("R11 bad rsvd dst", dst, OLD);
    check("R11 bad rsvd fault+flags", 256'({ud_fault, flags}), 256'({1'b1, 5'h00}));
    run_op({SNN, BIG, TIE, ONE}, OLD, 2'b11, 2'b00, 4'hF);
    check("R11 bad variant fault", 256'(ud_fault), 256'(1));
    check("R11 bad variant dst", dst, OLD);
    run_op({SNN, BIG, TIE, ONE}, OLD, 2'b01, 2'b00, 4'hF);
    check("R11 fault clears", 256'(ud_fault), 256'(0));

    // R12 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    src = {128'd0, M25, ONE}; old_dst = OLD; vsel = 2'b01; rmode = 2'b00; rsvd = 4'hF;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    src = {128'd0, ONE, M25};
    check("R12 stalled in_ready", 256'({out_valid, in_ready}), 256'(2'b10));
    @(posedge clk);
    @(negedge clk);
    check("R12 held dst", dst, {192'd0, 32'hC0200000, 32'h3F800000});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R12 next op taken", dst, {192'd0, 32'h3F800000, 32'hC0200000});
    @(posedge clk);
    @(negedge clk);
    check("R12 valid drops", 256'(out_valid), 256'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule